// File: doc/BRIEF.md
# UART Register Window

This block sits between a processor's load/store path and a pair of byte-wide serial cores, one for transmit and one for receive. It occupies a small window at the start of the I/O region and answers three word addresses in it. The first is a status word that reports whether the transmitter can take a byte and whether a received byte is waiting. The second returns the waiting received byte. The third takes a byte to send. The serial link itself runs at 115200 baud inside the serial cores. This block only decodes the processor's accesses and drives the handshakes to those cores.

Loads are answered one cycle after the access, in the same way as a synchronous memory, so the writeback mux can treat this block like any other read port. A load of the received-data word consumes the byte. It raises a one-cycle dequeue strobe, and the receiver drops its valid flag in the next cycle. A store to the transmit address starts a send only when its low byte lane is enabled and the transmitter reports ready. Any other store is dropped without side effects.

Top module: `uart_reg_window`

## Requirements
- R1: After reset, and in every cycle that follows a cycle without a load, `rd_data_o` is zero.
- R2: A load from the base address (byte offset 0x0) returns, one cycle later, a word whose bit 0 is the transmitter-ready input and whose bit 1 is the receive-valid input, both as sampled in the load cycle. All other bits are zero.
- R3: A load from byte offset 0x4 returns, one cycle later, the received byte in bits 7:0 as sampled in the load cycle, with bits 31:8 zero.
- R4: `rx_deq_o` is high in exactly those cycles that carry a load from offset 0x4 while `rx_valid_i` is high. It is a single-cycle strobe for each such load.
- R5: A store to offset 0x8 with write strobe bit 0 set while `tx_ready_i` is high raises `tx_valid_o` in the same cycle, with `tx_data_o` equal to write-data bits 7:0.
- R6: A store to offset 0x8 while `tx_ready_i` is low is dropped, and `tx_valid_o` stays low.
- R7: A store to offset 0x8 with write strobe bit 0 clear does not raise `tx_valid_o`.
- R8: A load from any other address returns zero one cycle later. This covers offset 0xC, misaligned offsets, the write-only offset 0x8, and addresses outside the window.
- R9: Stores to offsets 0x0 and 0x4, and loads of any kind, never raise `tx_valid_o`. Stores never raise `rx_deq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 32 | Byte address of the processor access |
| rd_en_i | input | 1 | Load in this cycle |
| wr_en_i | input | 1 | Store in this cycle |
| wstrb_i | input | 4 | Byte-lane enables of the store |
| wdata_i | input | 32 | Store data |
| rd_data_o | output | 32 | Load result, valid the cycle after the load |
| tx_ready_i | input | 1 | Transmitter can accept a byte |
| tx_valid_o | output | 1 | Byte offered to the transmitter |
| tx_data_o | output | 8 | Byte to transmit |
| rx_valid_i | input | 1 | Receiver holds a byte |
| rx_data_i | input | 8 | Received byte |
| rx_deq_o | output | 1 | Receiver byte consumed this cycle |

## Verification
The bench keeps a receive queue and a model of the transmitter-ready line, and it compares every output in every cycle. Status reads are issued under all four combinations of transmitter-ready and receive-valid, which shows that each bit comes from its own input. Back-to-back data reads against a queue of distinct bytes, followed by a read of the empty queue, show that a byte is consumed exactly once and that no dequeue is raised when nothing is waiting. Stores vary the ready line, the low strobe bit, the target offset and the upper data bits, which separates a launched byte from a dropped one. A long stretch of mixed accesses, including loads and stores in the same cycle, checks for interference between the two paths.

// File: rtl/uart_reg_window.sv
module uart_reg_window #(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter int          STRB_W    = DATA_W / 8,
  parameter int          BYTE_W    = 8,
  parameter int          WIN_LOG   = 4,
  parameter logic [31:0] BASE_ADDR = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [STRB_W-1:0] wstrb_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              tx_ready_i,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic              rx_deq_o
);

  localparam logic [ADDR_W-1:0] BASE    = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT  = BASE;
  localparam logic [ADDR_W-1:0] A_RXD   = BASE + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_TXD   = BASE + ADDR_W'(8);

  logic sel_stat, sel_rxd, sel_txd;
  logic [DATA_W-1:0] rd_next;
  logic unused_bits;

  assign sel_stat = (addr_i == A_STAT);
  assign sel_rxd  = (addr_i == A_RXD);
  assign sel_txd  = (addr_i == A_TXD);

  assign tx_valid_o = wr_en_i && sel_txd && wstrb_i[0] && tx_ready_i;
  assign tx_data_o  = wdata_i[BYTE_W-1:0];
  assign rx_deq_o   = rd_en_i && sel_rxd && rx_valid_i;

  always_comb begin
    rd_next = '0;
    if (rd_en_i) begin
      if (sel_stat) rd_next = {{(DATA_W-2){1'b0}}, rx_valid_i, tx_ready_i};
      else if (sel_rxd) rd_next = {{(DATA_W-BYTE_W){1'b0}}, rx_data_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data_o <= '0;
    else        rd_data_o <= rd_next;
  end

  assign unused_bits = ^{wdata_i[DATA_W-1:BYTE_W], wstrb_i[STRB_W-1:1], WIN_LOG[0]};

  // R1
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> rd_data_o == '0);

  // R2
  status_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == A_STAT) |=>
      rd_data_o == {{(DATA_W-2){1'b0}}, $past(rx_valid_i), $past(tx_ready_i)});

  // R3
  rx_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == A_RXD) |=> rd_data_o == {{(DATA_W-BYTE_W){1'b0}}, $past(rx_data_i)});

  // R4
  deq_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_deq_o |-> (rx_valid_i && rd_en_i));

  // R6
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready_i |-> !tx_valid_o);

  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i != A_STAT && addr_i != A_RXD) |=> rd_data_o == '0);

  // R9
  tx_only_on_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> (wr_en_i && addr_i == A_TXD));

endmodule

// File: tb/tb_uart_reg_window.sv
module tb_uart_reg_window;
  localparam logic [31:0] BASE = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [3:0]  wstrb = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic        tx_ready = 1'b0, tx_valid;
  logic [7:0]  tx_data;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_deq;

  int checks = 0, fails = 0;
  logic [7:0]  rxq[$];
  logic [31:0] exp_rd = '0;

  always #4 clk = ~clk;

  assign rx_valid = rxq.size() > 0;
  assign rx_data  = (rxq.size() > 0) ? rxq[0] : 8'h00;

  uart_reg_window dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .wstrb_i(wstrb), .wdata_i(wdata), .rd_data_o(rd_data),
    .tx_ready_i(tx_ready), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_deq_o(rx_deq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic w, input logic [31:0] a,
                      input logic [3:0] s, input logic [31:0] d, input logic tr,
                      input string req);
    logic        e_deq, e_txv;
    logic [31:0] nxt;
    @(negedge clk);
    rd_en = r; wr_en = w; addr = a; wstrb = s; wdata = d; tx_ready = tr;
    #2;
    e_deq = r && (a == BASE + 4) && (rxq.size() > 0);
    e_txv = w && (a == BASE + 8) && s[0] && tr;
    nxt = '0;
    if (r && a == BASE)     nxt = {30'b0, rxq.size() > 0, tr};
    if (r && a == BASE + 4) nxt = {24'b0, rx_data};
    chk({req, " rd_data"}, rd_data, exp_rd);
    chk({req, " rx_deq"}, {31'b0, rx_deq}, {31'b0, e_deq});
    chk({req, " tx_valid"}, {31'b0, tx_valid}, {31'b0, e_txv});
    if (e_txv) chk({req, " tx_data"}, {24'b0, tx_data}, {24'b0, d[7:0]});
    @(posedge clk);
    #1;
    exp_rd = nxt;
    if (e_deq) void'(rxq.pop_front());
  endtask

  task automatic idle(input string req);
    step(1'b0, 1'b0, BASE, 4'h0, '0, tx_ready, req);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    idle("R1");
    idle("R1");
    // R2 all four status combinations
    step(1, 0, BASE, 0, 0, 0, "R2");
    step(1, 0, BASE, 0, 0, 1, "R2");
    rxq.push_back(8'hA5);
    step(1, 0, BASE, 0, 0, 0, "R2");
    step(1, 0, BASE, 0, 0, 1, "R2");
    idle("R1");
    // R3 R4 back-to-back consumption
    rxq.push_back(8'h3C);
    rxq.push_back(8'hFF);
    step(1, 0, BASE + 4, 0, 0, 0, "R3 R4");
    step(1, 0, BASE + 4, 0, 0, 0, "R3 R4");
    step(1, 0, BASE + 4, 0, 0, 0, "R3 R4");
    step(1, 0, BASE + 4, 0, 0, 0, "R3 R4 empty");
    step(1, 0, BASE, 0, 0, 0, "R2 empty");
    idle("R1");
    // R5 launch
    step(0, 1, BASE + 8, 4'h1, 32'hDEAD_BE5A, 1, "R5");
    step(0, 1, BASE + 8, 4'hF, 32'h1234_5600, 1, "R5");
    // R6 drop when busy
    step(0, 1, BASE + 8, 4'hF, 32'h0000_0077, 0, "R6");
    idle("R6");
    // R7 no low strobe
    step(0, 1, BASE + 8, 4'hE, 32'h0000_0011, 1, "R7");
    step(0, 1, BASE + 8, 4'h0, 32'h0000_0011, 1, "R7");
    // R9 stores elsewhere, leave queue intact
    rxq.push_back(8'h5E);
    step(0, 1, BASE, 4'hF, 32'hFFFF_FFFF, 1, "R9");
    step(0, 1, BASE + 4, 4'hF, 32'hFFFF_FFFF, 1, "R9");
    step(1, 0, BASE, 0, 0, 1, "R9 queue kept");
    // R8 unmapped
    step(1, 0, BASE + 12, 0, 0, 1, "R8");
    step(1, 0, BASE + 5, 0, 0, 1, "R8");
    step(1, 0, BASE + 8, 0, 0, 1, "R8");
    step(1, 0, BASE + 16, 0, 0, 1, "R8");
    step(1, 0, 32'h1000_0004, 0, 0, 1, "R8");
    step(1, 0, BASE + 4, 0, 0, 1, "R3 after R8");
    idle("R1");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      logic [1:0]  sel;
      sel = 2'($urandom_range(0, 3));
      a = (sel == 3) ? BASE + 32'($urandom_range(0, 31)) : BASE + {28'b0, sel, 2'b00};
      if ($urandom_range(0, 5) == 0) rxq.push_back(8'($urandom));
      step(1'($urandom), 1'($urandom), a, 4'($urandom), $urandom, 1'($urandom), "R9 mixed");
    end
    idle("R1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule